// File: doc/BRIEF.md
# SDIO Card Bring-Up Sequencer

This block sits on the host side of an SDIO link and walks an I/O card from power-on to a selected, configured state. It does not touch the physical bus. Instead it hands one command at a time to a separate command engine through a simple handshake. It presents a 6-bit command index and a 32-bit argument, then waits for either a completion pulse carrying the 32-bit response word or a timeout pulse.

The script is fixed, with two optional steps that are chosen by inputs:
- It resets the card's I/O section and then the card as a whole.
- It optionally probes the interface condition.
- It polls the operating-condition command until the card reports ready.
- It reads the card's relative address and selects the card with it.
- It optionally switches the bus to 4 data lines.
- It enables function 1 and the card's interrupts.
- It programs the block size of functions 0 and 1, and reads each byte back to confirm it.

The sequencer ends in a done state or in an error state. In the error state a code gives the reason.

Top module: `sdio_init_seq`

## Requirements
- R1: After reset, cmd_valid, done and error are low, and err_code and rca are zero. A start pulse is accepted only while no sequence is running.
- R2: A start pulse during a running sequence has no effect on the commands issued or on the outcome.
- R3: The first command is CMD52 with argument 0x80000C08. The second is CMD0 with argument 0. Every byte-access argument uses this layout: bit 31 is write, bits 30:28 are the function (always 0), bit 27 is 0, bits 25:9 are the register address, and bits 7:0 are the data.
- R4: When skip_probe is low, CMD8 with argument 0x000001AA follows CMD0. When skip_probe is high, CMD8 is not sent.
- R5: The first CMD5 has argument 0. If its response bit 31 is 0, further CMD5s are sent with argument {8'h00, bits 23:0 of that first response} until a response has bit 31 set.
- R6: If retry_limit (which must be at least 1) poll responses in a row report not ready, the sequencer stops with error and err_code 2.
- R7: CMD3 follows readiness. Bits 31:16 of its response are shown on rca. The next command is CMD7 with argument {rca, 16'h0000}.
- R8: When wide_bus is high, a write of 0x02 to address 0x07 follows CMD7. When wide_bus is low, this write is not sent.
- R9: A write of 0x02 to address 0x02 is sent next, then a write of 0x03 to address 0x04.
- R10: Next come writes of BLK_SIZE[7:0] to 0x10 and BLK_SIZE[15:8] to 0x11, then reads of 0x10 and 0x11. The same four accesses then follow at 0x110 and 0x111.
- R11: If the low byte of a read's response differs from the byte written, the sequencer stops with error, err_code 3 and done low.
- R12: A timeout pulse stops the sequencer at once with error and err_code 1. No further command is issued.
- R13: cmd_valid and the command fields stay stable until a completion or timeout pulse arrives.
- R14: Done rises right after the last read-back completes with a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin the sequence |
| skip_probe | input | 1 | Leave out CMD8 |
| wide_bus | input | 1 | Switch to 4 data lines |
| retry_limit | input | RETRY_W | Number of not-ready polls tolerated |
| cmd_valid | output | 1 | A command is pending |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| rsp_done | input | 1 | Command completed; rsp_word is valid |
| rsp_timeout | input | 1 | Command got no response |
| rsp_word | input | 32 | Response word |
| done | output | 1 | Sequence finished successfully |
| error | output | 1 | Sequence stopped on a fault |
| err_code | output | 2 | 1 = timeout, 2 = poll limit, 3 = read-back mismatch |
| rca | output | 16 | Captured relative card address |

## Verification
The bench uses the default 512-byte block size and an 8-bit retry counter, and drives retry_limit with 1 and 2. Small limits put both sides of the poll-exhaustion boundary within reach: a card that becomes ready on the last allowed poll, and one that is ready one poll too late. The bench sweeps every combination of the two optional steps against ready delays from 0 to 3 polls. It injects a timeout at every command position of a full run, and it corrupts each of the four read-backs in turn.

// File: rtl/sdio_init_seq.sv
module sdio_init_seq #(
  parameter int RETRY_W = 8,
  parameter logic [15:0] BLK_SIZE = 16'h0200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               skip_probe,
  input  logic               wide_bus,
  input  logic [RETRY_W-1:0] retry_limit,
  output logic               cmd_valid,
  output logic [5:0]         cmd_idx,
  output logic [31:0]        cmd_arg,
  input  logic               rsp_done,
  input  logic               rsp_timeout,
  input  logic [31:0]        rsp_word,
  output logic               done,
  output logic               error,
  output logic [1:0]         err_code,
  output logic [15:0]        rca
);
  localparam logic [4:0] LAST = 5'd17;
  localparam logic [7:0] BLO = BLK_SIZE[7:0];
  localparam logic [7:0] BHI = BLK_SIZE[15:8];

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE, S_FAIL} st_t;
  st_t st;
  logic [4:0]         step, step_inc;
  logic [RETRY_W-1:0] polls;
  logic [23:0]        ocr;
  logic [7:0]         want;
  logic               is_rb;

  function automatic logic [31:0] b52(input logic wr, input logic [16:0] a, input logic [7:0] d);
    return {wr, 3'd0, 1'b0, 1'b0, a, 1'b0, d};
  endfunction

  assign cmd_valid = (st == S_RUN);
  assign done      = (st == S_DONE);
  assign error     = (st == S_FAIL);

  always_comb begin
    step_inc = step + 5'd1;
    if (step_inc == 5'd2 && skip_probe) step_inc = 5'd3;
    if (step_inc == 5'd7 && !wide_bus)  step_inc = 5'd8;
  end

  always_comb begin
    cmd_idx = 6'd52;
    cmd_arg = 32'h0;
    want    = 8'h00;
    is_rb   = 1'b0;
    case (step)
      5'd0:  cmd_arg = b52(1'b1, 17'h6, 8'h08);
      5'd1:  cmd_idx = 6'd0;
      5'd2:  begin cmd_idx = 6'd8; cmd_arg = 32'h0000_01AA; end
      5'd3:  cmd_idx = 6'd5;
      5'd4:  begin cmd_idx = 6'd5; cmd_arg = {8'h00, ocr}; end
      5'd5:  cmd_idx = 6'd3;
      5'd6:  begin cmd_idx = 6'd7; cmd_arg = {rca, 16'h0000}; end
      5'd7:  cmd_arg = b52(1'b1, 17'h7, 8'h02);
      5'd8:  cmd_arg = b52(1'b1, 17'h2, 8'h02);
      5'd9:  cmd_arg = b52(1'b1, 17'h4, 8'h03);
      5'd10: cmd_arg = b52(1'b1, 17'h10, BLO);
      5'd11: cmd_arg = b52(1'b1, 17'h11, BHI);
      5'd12: begin cmd_arg = b52(1'b0, 17'h10, 8'h00); want = BLO; is_rb = 1'b1; end
      5'd13: begin cmd_arg = b52(1'b0, 17'h11, 8'h00); want = BHI; is_rb = 1'b1; end
      5'd14: cmd_arg = b52(1'b1, 17'h110, BLO);
      5'd15: cmd_arg = b52(1'b1, 17'h111, BHI);
      5'd16: begin cmd_arg = b52(1'b0, 17'h110, 8'h00); want = BLO; is_rb = 1'b1; end
      default: begin cmd_arg = b52(1'b0, 17'h111, 8'h00); want = BHI; is_rb = 1'b1; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      step     <= 5'd0;
      polls    <= '0;
      ocr      <= 24'h0;
      rca      <= 16'h0;
      err_code <= 2'd0;
    end else if (st != S_RUN) begin
      if (start) begin
        st       <= S_RUN;
        step     <= 5'd0;
        polls    <= '0;
        rca      <= 16'h0;
        err_code <= 2'd0;
      end
    end else if (rsp_timeout) begin
      st       <= S_FAIL;
      err_code <= 2'd1;
    end else if (rsp_done) begin
      if (step == 5'd3) begin
        ocr  <= rsp_word[23:0];
        step <= rsp_word[31] ? 5'd5 : 5'd4;
      end else if (step == 5'd4) begin
        if (rsp_word[31]) step <= 5'd5;
        else if ({1'b0, polls} + 1'b1 >= {1'b0, retry_limit}) begin
          st       <= S_FAIL;
          err_code <= 2'd2;
        end else polls <= polls + 1'b1;
      end else if (is_rb && rsp_word[7:0] != want) begin
        st       <= S_FAIL;
        err_code <= 2'd3;
      end else if (step == LAST) begin
        st <= S_DONE;
      end else begin
        if (step == 5'd5) rca <= rsp_word[31:16];
        step <= step_inc;
      end
    end
  end
endmodule

module sdio_init_seq_chk #(
  parameter int RETRY_W = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [5:0]  cmd_idx,
  input logic [31:0] cmd_arg,
  input logic        rsp_done,
  input logic        rsp_timeout,
  input logic        done,
  input logic        error,
  input logic [15:0] rca
);
  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !rsp_done && !rsp_timeout |=> cmd_valid && $stable(cmd_idx) && $stable(cmd_arg));
  a_r12_timeout_stops: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && rsp_timeout |=> error && !cmd_valid);
  a_r7_select_arg: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_idx == 6'd7 |-> cmd_arg == {rca, 16'h0000});
  a_r14_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cmd_valid && rsp_done && cmd_idx == 6'd52 && !cmd_arg[31]));
  a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error) && !(cmd_valid && (done || error)));
endmodule

bind sdio_init_seq sdio_init_seq_chk #(.RETRY_W(RETRY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_idx(cmd_idx),
  .cmd_arg(cmd_arg), .rsp_done(rsp_done), .rsp_timeout(rsp_timeout),
  .done(done), .error(error), .rca(rca)
);

// File: tb/sdio_init_seq_tb.sv
module sdio_init_seq_tb;
  logic clk = 0, rst_n = 0, start = 0, skip_probe = 0, wide_bus = 0;
  logic [7:0]  retry_limit = 8'd1;
  logic        cmd_valid, rsp_done = 0, rsp_timeout = 0, done, error;
  logic [5:0]  cmd_idx;
  logic [31:0] cmd_arg, rsp_word = 0;
  logic [1:0]  err_code;
  logic [15:0] rca;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  sdio_init_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .skip_probe(skip_probe),
    .wide_bus(wide_bus), .retry_limit(retry_limit), .cmd_valid(cmd_valid),
    .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .rsp_done(rsp_done),
    .rsp_timeout(rsp_timeout), .rsp_word(rsp_word), .done(done),
    .error(error), .err_code(err_code), .rca(rca)
  );

  logic [5:0]  e_idx [0:39];
  logic [31:0] e_arg [0:39];
  int e_n;
  logic [5:0]  g_idx [0:39];
  logic [31:0] g_arg [0:39];
  int g_n;
  logic [7:0] bytes [0:3];

  function automatic logic [31:0] acc(input logic wr, input logic [16:0] a, input logic [7:0] d);
    return {wr, 3'd0, 2'b00, a, 1'b0, d};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [5:0] i, input logic [31:0] a);
    e_idx[e_n] = i; e_arg[e_n] = a; e_n++;
  endtask

  // Expected script per R3..R10; returns 1 if the poll limit is hit (R6)
  task automatic build(input bit sk, input bit wd, input int n, input int lim,
                       input logic [15:0] rv, input logic [23:0] ov, output bit plimit);
    int polls;
    e_n = 0; plimit = 0;
    push(6'd52, acc(1, 17'h6, 8'h08)); push(6'd0, 32'h0);
    if (!sk) push(6'd8, 32'h1AA);
    push(6'd5, 32'h0);
    polls = (n > lim) ? lim : n;
    for (int k = 0; k < polls; k++) push(6'd5, {8'h00, ov});
    if (n > lim) begin plimit = 1; return; end
    push(6'd3, 32'h0); push(6'd7, {rv, 16'h0});
    if (wd) push(6'd52, acc(1, 17'h7, 8'h02));
    push(6'd52, acc(1, 17'h2, 8'h02)); push(6'd52, acc(1, 17'h4, 8'h03));
    push(6'd52, acc(1, 17'h10, 8'h00)); push(6'd52, acc(1, 17'h11, 8'h02));
    push(6'd52, acc(0, 17'h10, 8'h00)); push(6'd52, acc(0, 17'h11, 8'h00));
    push(6'd52, acc(1, 17'h110, 8'h00)); push(6'd52, acc(1, 17'h111, 8'h02));
    push(6'd52, acc(0, 17'h110, 8'h00)); push(6'd52, acc(0, 17'h111, 8'h00));
  endtask

  function automatic int slot(input logic [16:0] a);
    case (a)
      17'h10: return 0; 17'h11: return 1; 17'h110: return 2; 17'h111: return 3;
      default: return -1;
    endcase
  endfunction

  // Responder; tmo_at = command number to time out (-1 none), bad_rb = read-back to corrupt
  task automatic run(input bit sk, input bit wd, input int n, input int lim,
                     input logic [15:0] rv, input logic [23:0] ov,
                     input int tmo_at, input int bad_rb, input bit restart_mid);
    int polls5, rbs, cyc, s;
    g_n = 0; polls5 = -1; rbs = 0; cyc = 0;
    skip_probe = sk; wide_bus = wd; retry_limit = 8'(lim);
    for (int i = 0; i < 4; i++) bytes[i] = 8'hEE;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    while (cyc < 400) begin
      @(negedge clk); cyc++;
      if (done || error) break;
      if (cmd_valid) begin
        g_idx[g_n] = cmd_idx; g_arg[g_n] = cmd_arg;
        rsp_word = 32'h0;
        if (cmd_idx == 6'd5) begin
          polls5++;
          rsp_word = {(polls5 == n) ? 1'b1 : 1'b0, 7'h0, ov};
        end else if (cmd_idx == 6'd3) rsp_word = {rv, 16'h1234};
        else if (cmd_idx == 6'd52) begin
          s = slot(cmd_arg[25:9]);
          if (cmd_arg[31] && s >= 0) bytes[s] = cmd_arg[7:0];
          else if (!cmd_arg[31] && s >= 0) begin
            rsp_word[7:0] = bytes[s] ^ ((rbs == bad_rb) ? 8'h01 : 8'h00);
            rsp_word[31:8] = 24'hABCDEF;
            rbs++;
          end
        end
        if (g_n == tmo_at) rsp_timeout = 1; else rsp_done = 1;
        if (restart_mid && g_n == 2) start = 1;
        g_n++;
        @(negedge clk);
        rsp_done = 0; rsp_timeout = 0; start = 0;
      end
    end
  endtask

  task automatic compare(input string req);
    int bad = -1;
    if (g_n != e_n) bad = 99;
    else for (int i = 0; i < e_n; i++)
      if (bad < 0 && (g_idx[i] != e_idx[i] || g_arg[i] != e_arg[i])) bad = i;
    if (bad < 0) chk(1, req, 0, 0);
    else if (bad == 99) chk(0, {req, " command count"}, g_n, e_n);
    else chk(0, {req, " command"}, {g_idx[bad], g_arg[bad]}, {e_idx[bad], e_arg[bad]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit pl;
    int full;
    logic [15:0] rv;
    logic [23:0] ov;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!cmd_valid && !done && !error && err_code == 0 && rca == 0, "R1 reset",
        {cmd_valid, done, error, err_code, rca}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!cmd_valid, "R1 idle without start", cmd_valid, 0);

    // R3 R4 R5 R6 R7 R8 R9 R10 R14 sweep
    for (int cfg = 0; cfg < 4; cfg++)
      for (int lim = 1; lim <= 2; lim++)
        for (int n = 0; n <= 3; n++) begin
          rv = 16'h0001 + 16'(cfg * 16 + n * 4 + lim);
          ov = 24'hFFFF00 ^ 24'(n << 8);
          build(cfg[0], cfg[1], n, lim, rv, ov, pl);
          run(cfg[0], cfg[1], n, lim, rv, ov, -1, -1, 0);
          compare("R3/R4/R5/R8/R9/R10 sequence");
          if (pl) chk(error && !done && err_code == 2, "R6 poll limit", {error, done, err_code}, 4'b1010);
          else begin
            chk(done && !error, "R14 done", {done, error}, 2'b10);
            chk(rca == rv, "R7 rca", rca, rv);
          end
        end

    // R2: start during a run has no effect
    build(0, 1, 2, 2, 16'hBEEF, 24'hFF8000, pl);
    run(0, 1, 2, 2, 16'hBEEF, 24'hFF8000, -1, -1, 1);
    compare("R2 start ignored");
    chk(done && !error && rca == 16'hBEEF, "R2 outcome", {done, error, rca}, {2'b10, 16'hBEEF});

    // R12: timeout at every command position
    build(0, 1, 1, 2, 16'h0042, 24'hFFFF00, pl);
    full = e_n;
    for (int t = 0; t < full; t++) begin
      build(0, 1, 1, 2, 16'h0042, 24'hFFFF00, pl);
      e_n = t + 1;
      run(0, 1, 1, 2, 16'h0042, 24'hFFFF00, t, -1, 0);
      compare("R12 stop on timeout");
      chk(error && !done && err_code == 1, "R12 code", {error, done, err_code}, 4'b1001);
      @(negedge clk);
      chk(!cmd_valid, "R12 no further command", cmd_valid, 0);
    end

    // R11: corrupt each read-back
    for (int j = 0; j < 4; j++)
      for (int wd = 0; wd < 2; wd++) begin
        build(1, wd[0], 0, 1, 16'h7777, 24'hFF0000, pl);
        e_n = e_n - 4 * (j < 2 ? 1 : 0) - (j == 0 || j == 2 ? 1 : 0);
        run(1, wd[0], 0, 1, 16'h7777, 24'hFF0000, -1, j, 0);
        compare("R11 stop on mismatch");
        chk(error && !done && err_code == 3, "R11 code", {error, done, err_code}, 4'b1011);
      end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule